// File: doc/BRIEF.md
# Shared Program and Swap Memory Decoder

This block sits between a small embedded CPU and an external host bus and owns the two memories they share. One is the program RAM that the CPU boots from. The other is a swap buffer that both sides use to pass data to each other. Each side sees the memories at its own addresses. On the CPU side, program RAM is at address zero and the swap buffer follows at 0x8000. On the host side, the same two regions sit above a base address set by a parameter.

The host loads the CPU program by writing program RAM while it holds the CPU in reset through an active-low run input. Once the CPU is released, the host is locked out of program RAM. The swap buffer stays open to both ports. CPU addresses in the top 256 bytes of the address space do not reach either RAM. They raise a select for an external peripheral block instead.

Both ports move 32-bit words with per-byte write enables. Read data appears on the cycle after the request.

Top module: `shared_mem_decoder`

## Requirements
- R1: A CPU access with an address in 0x0000_0000..0x0000_7FFF reaches program RAM. The data returns on `cpuRdata` one clock after the request. A program RAM smaller than 32 KB repeats through that window, so the word used is address modulo `PROG_BYTES`.
- R2: A CPU access with an address from 0x0000_8000 up to 0x0000_8000 + `BUF_BYTES` - 1 reaches the swap buffer.
- R3: The host sees program RAM at `HOST_BASE` + 0x0000..0x7FFF and the swap buffer at `HOST_BASE` + 0x8000. `HOST_BASE` defaults to 0x8000_0000. Host read data returns on `hostRdata` one clock after the strobe.
- R4: When `cpuResetN` is 1 (CPU running), host accesses to program RAM are blocked. A blocked write leaves the memory unchanged, and a blocked read returns zero. When `cpuResetN` is 0, these accesses go through.
- R5: Data that either port writes into the swap buffer can be read back by the other port.
- R6: Only the byte lanes whose write-enable bit is set are written. Bit k of `cpuBe` or `hostBe` enables data bits 8k+7..8k.
- R7: If both ports write the same swap buffer word in the same cycle, each byte lane the CPU enables takes the CPU data. Lanes that only the host enables take the host data. Lanes that neither port enables keep their old value.
- R8: A CPU request at an address of 0xFFFF_FF00 or above drives `cpuPeriphSel` high in the same cycle. It touches neither RAM and returns zero on `cpuRdata`.
- R9: Accesses that decode to no region are handled the same way on both ports. Writes are dropped, and reads return zero.
- R10: Words that the host writes at program offsets 0x00 (boot vector) and 0x20 (interrupt entry) while the CPU is in reset are read by the CPU at addresses 0x0 and 0x20 after release.
- R11: An access that reads and writes the same word returns the word's contents from before the write.
- R12: While `rstN` is low, and on the first sample after it, both read data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Synchronous active-low reset for the read path |
| cpuResetN | input | 1 | Low holds the CPU in reset and opens program RAM to the host |
| cpuReq | input | 1 | CPU access request |
| cpuWe | input | 1 | CPU write (with cpuReq) |
| cpuAddr | input | 32 | CPU byte address |
| cpuBe | input | 4 | CPU byte write enables |
| cpuWdata | input | 32 | CPU write data |
| cpuRdata | output | 32 | CPU read data, one cycle after the request |
| cpuPeriphSel | output | 1 | CPU request targets the peripheral space |
| hostAddr | input | 32 | Host byte address |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostBe | input | 4 | Host byte write enables |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, one cycle after the strobe |

## Verification
The hardest case to reach from the ports is a host write and a CPU write landing on the same swap buffer word in the same clock. On top of that, every pairing of byte enables has to be covered, because the lane-by-lane priority only shows up in the bytes where the enables overlap. The bench sets up that same-cycle collision for all 256 combinations of the two 4-bit enables. Before each collision it clears the word to a known value, and after it reads the word back through the host port. The lockout is exercised by running the same host program write once before and once after `cpuResetN` rises, and then reading the target word through the CPU port.

// File: rtl/shmem_pkg.sv
package shmem_pkg;

  localparam int WORD_BITS = 32;
  localparam int LANES     = WORD_BITS / 8;

  // Decoded strobes handed from control to datapath
  typedef struct packed {
    logic cpuProg;   // CPU access hits program RAM
    logic cpuBuf;    // CPU access hits swap buffer
    logic cpuWr;     // CPU access is a write
    logic hostProg;  // host access hits program RAM (lock applied)
    logic hostBuf;   // host access hits swap buffer
    logic hostWr;    // host access is a write
  } memStrobes_t;

endpackage

// File: rtl/shmem_ram2p.sv
module shmem_ram2p #(
  parameter int WORDS = 2048,
  parameter int AW    = 11
) (
  input  logic                                    clk,
  input  logic                                    aEn,
  input  logic                                    aWe,
  input  logic [AW-1:0]                           aIdx,
  input  logic [shmem_pkg::LANES-1:0]             aBe,
  input  logic [shmem_pkg::WORD_BITS-1:0]         aWd,
  output logic [shmem_pkg::WORD_BITS-1:0]         aQ,
  input  logic                                    bEn,
  input  logic                                    bWe,
  input  logic [AW-1:0]                           bIdx,
  input  logic [shmem_pkg::LANES-1:0]             bBe,
  input  logic [shmem_pkg::WORD_BITS-1:0]         bWd,
  output logic [shmem_pkg::WORD_BITS-1:0]         bQ
);
  import shmem_pkg::*;

  logic [WORD_BITS-1:0] mem [WORDS];

  // Read-first on both ports; port A (CPU) is written last so it owns
  // any byte lane both ports enable in the same cycle.
  always_ff @(posedge clk) begin
    if (aEn) aQ <= mem[aIdx];
    if (bEn) bQ <= mem[bIdx];
    for (int k = 0; k < LANES; k++) begin
      if (bEn && bWe && bBe[k]) mem[bIdx][k*8 +: 8] <= bWd[k*8 +: 8];
      if (aEn && aWe && aBe[k]) mem[aIdx][k*8 +: 8] <= aWd[k*8 +: 8];
    end
  end

endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl #(
  parameter logic [31:0] HOST_BASE   = 32'h8000_0000,
  parameter int          PROG_SPAN   = 32768,
  parameter int          BUF_BYTES   = 8192,
  parameter logic [31:0] PERIPH_BASE = 32'hFFFF_FF00
) (
  input  logic                   cpuResetN,
  input  logic                   cpuReq,
  input  logic                   cpuWe,
  input  logic [31:0]            cpuAddr,
  input  logic                   hostRd,
  input  logic                   hostWr,
  input  logic [31:0]            hostAddr,
  output shmem_pkg::memStrobes_t strobes,
  output logic                   cpuPeriphSel
);
  import shmem_pkg::*;

  localparam logic [31:0] PROG_END = 32'(PROG_SPAN);
  localparam logic [31:0] BUF_END  = 32'(PROG_SPAN + BUF_BYTES);

  logic [31:0] hostOff;
  logic        hostAct;
  logic        hostAbove;
  logic        cpuInPeriph;

  assign hostOff     = hostAddr - HOST_BASE;
  assign hostAct     = hostRd | hostWr;
  assign hostAbove   = (hostAddr >= HOST_BASE);
  assign cpuInPeriph = (cpuAddr >= PERIPH_BASE);

  always_comb begin
    strobes          = '0;
    strobes.cpuProg  = cpuReq && !cpuInPeriph && (cpuAddr < PROG_END);
    strobes.cpuBuf   = cpuReq && !cpuInPeriph && (cpuAddr >= PROG_END) && (cpuAddr < BUF_END);
    strobes.cpuWr    = cpuWe;
    strobes.hostProg = hostAct && hostAbove && (hostOff < PROG_END) && !cpuResetN;
    strobes.hostBuf  = hostAct && hostAbove && (hostOff >= PROG_END) && (hostOff < BUF_END);
    strobes.hostWr   = hostWr;
  end

  assign cpuPeriphSel = cpuReq && cpuInPeriph;

endmodule

// File: rtl/shmem_dpath.sv
module shmem_dpath #(
  parameter int PROG_BYTES = 8192,
  parameter int BUF_BYTES  = 8192,
  parameter int PAW        = 11,
  parameter int BAW        = 11
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  shmem_pkg::memStrobes_t              strobes,
  input  logic [PAW-1:0]                      cpuProgIdx,
  input  logic [BAW-1:0]                      cpuBufIdx,
  input  logic [shmem_pkg::LANES-1:0]         cpuBe,
  input  logic [shmem_pkg::WORD_BITS-1:0]     cpuWdata,
  input  logic [PAW-1:0]                      hostProgIdx,
  input  logic [BAW-1:0]                      hostBufIdx,
  input  logic [shmem_pkg::LANES-1:0]         hostBe,
  input  logic [shmem_pkg::WORD_BITS-1:0]     hostWdata,
  output logic [shmem_pkg::WORD_BITS-1:0]     cpuRdata,
  output logic [shmem_pkg::WORD_BITS-1:0]     hostRdata
);
  import shmem_pkg::*;

  localparam int PROG_WORDS = PROG_BYTES / 4;
  localparam int BUF_WORDS  = BUF_BYTES / 4;

  logic [WORD_BITS-1:0] progCpuQ, progHostQ, bufCpuQ, bufHostQ;
  logic cpuSelProgQ, cpuSelBufQ, hostSelProgQ, hostSelBufQ;

  shmem_ram2p #(.WORDS(PROG_WORDS), .AW(PAW)) progRam_i (
    .clk (clk),
    .aEn (strobes.cpuProg),  .aWe (strobes.cpuWr),  .aIdx (cpuProgIdx),
    .aBe (cpuBe),            .aWd (cpuWdata),       .aQ   (progCpuQ),
    .bEn (strobes.hostProg), .bWe (strobes.hostWr), .bIdx (hostProgIdx),
    .bBe (hostBe),           .bWd (hostWdata),      .bQ   (progHostQ)
  );

  shmem_ram2p #(.WORDS(BUF_WORDS), .AW(BAW)) swapRam_i (
    .clk (clk),
    .aEn (strobes.cpuBuf),   .aWe (strobes.cpuWr),  .aIdx (cpuBufIdx),
    .aBe (cpuBe),            .aWd (cpuWdata),       .aQ   (bufCpuQ),
    .bEn (strobes.hostBuf),  .bWe (strobes.hostWr), .bIdx (hostBufIdx),
    .bBe (hostBe),           .bWd (hostWdata),      .bQ   (bufHostQ)
  );

  // Region selects follow the RAM read register by one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuSelProgQ  <= 1'b0;
      cpuSelBufQ   <= 1'b0;
      hostSelProgQ <= 1'b0;
      hostSelBufQ  <= 1'b0;
    end else begin
      cpuSelProgQ  <= strobes.cpuProg;
      cpuSelBufQ   <= strobes.cpuBuf;
      hostSelProgQ <= strobes.hostProg;
      hostSelBufQ  <= strobes.hostBuf;
    end
  end

  always_comb begin
    cpuRdata = '0;
    if (cpuSelProgQ)     cpuRdata = progCpuQ;
    else if (cpuSelBufQ) cpuRdata = bufCpuQ;
    hostRdata = '0;
    if (hostSelProgQ)     hostRdata = progHostQ;
    else if (hostSelBufQ) hostRdata = bufHostQ;
  end

endmodule

// File: rtl/shared_mem_decoder.sv
module shared_mem_decoder #(
  parameter logic [31:0] HOST_BASE   = 32'h8000_0000,
  parameter int          PROG_SPAN   = 32768,
  parameter int          PROG_BYTES  = 8192,
  parameter int          BUF_BYTES   = 8192,
  parameter logic [31:0] PERIPH_BASE = 32'hFFFF_FF00
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuResetN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic [31:0] cpuAddr,
  input  logic [3:0]  cpuBe,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  output logic        cpuPeriphSel,
  input  logic [31:0] hostAddr,
  input  logic        hostRd,
  input  logic        hostWr,
  input  logic [3:0]  hostBe,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata
);
  import shmem_pkg::*;

  localparam int PAW = $clog2(PROG_BYTES / 4);
  localparam int BAW = $clog2(BUF_BYTES / 4);

  memStrobes_t strobes;

  shmem_ctrl #(
    .HOST_BASE(HOST_BASE), .PROG_SPAN(PROG_SPAN),
    .BUF_BYTES(BUF_BYTES), .PERIPH_BASE(PERIPH_BASE)
  ) ctrl_i (
    .cpuResetN    (cpuResetN),
    .cpuReq       (cpuReq),
    .cpuWe        (cpuWe),
    .cpuAddr      (cpuAddr),
    .hostRd       (hostRd),
    .hostWr       (hostWr),
    .hostAddr     (hostAddr),
    .strobes      (strobes),
    .cpuPeriphSel (cpuPeriphSel)
  );

  shmem_dpath #(
    .PROG_BYTES(PROG_BYTES), .BUF_BYTES(BUF_BYTES), .PAW(PAW), .BAW(BAW)
  ) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cpuProgIdx  (cpuAddr[PAW+1:2]),
    .cpuBufIdx   (cpuAddr[BAW+1:2]),
    .cpuBe       (cpuBe),
    .cpuWdata    (cpuWdata),
    .hostProgIdx (hostAddr[PAW+1:2]),
    .hostBufIdx  (hostAddr[BAW+1:2]),
    .hostBe      (hostBe),
    .hostWdata   (hostWdata),
    .cpuRdata    (cpuRdata),
    .hostRdata   (hostRdata)
  );

endmodule

// File: rtl/shared_mem_decoder_chk.sv
module shared_mem_decoder_chk #(
  parameter logic [31:0] HOST_BASE   = 32'h8000_0000,
  parameter int          PROG_SPAN   = 32768,
  parameter logic [31:0] PERIPH_BASE = 32'hFFFF_FF00
) (
  input logic        clk,
  input logic        rstN,
  input logic        cpuResetN,
  input logic        cpuReq,
  input logic [31:0] cpuAddr,
  input logic        hostRd,
  input logic        hostWr,
  input logic [31:0] hostAddr,
  input logic        cpuPeriphSel,
  input logic [31:0] cpuRdata,
  input logic [31:0] hostRdata,
  input logic        cpuProgStb,
  input logic        cpuBufStb,
  input logic        hostProgStb
);
  localparam logic [31:0] PROG_END = 32'(PROG_SPAN);

  logic hostInProg;
  assign hostInProg = (hostRd || hostWr) && (hostAddr >= HOST_BASE) &&
                      ((hostAddr - HOST_BASE) < PROG_END);

  // R4: a program RAM access by the host while the CPU runs reads zero
  a_r4_locked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cpuResetN && hostInProg) |=> (hostRdata == 32'h0));

  // R4: the control never hands the datapath a host program strobe while running
  a_r4_no_prog_strobe: assert property (@(posedge clk) disable iff (!rstN)
    cpuResetN |-> !hostProgStb);

  // R8: peripheral addresses never enable either RAM
  a_r8_periph_no_ram: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReq && cpuAddr >= PERIPH_BASE) |-> !(cpuProgStb || cpuBufStb));

  // R8: a peripheral-space request returns zero on the CPU read port
  a_r8_periph_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    cpuPeriphSel |=> (cpuRdata == 32'h0));

  // R9: with no CPU request, the CPU read data is zero on the next cycle
  a_r9_cpu_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !cpuReq |=> (cpuRdata == 32'h0));

endmodule

bind shared_mem_decoder shared_mem_decoder_chk #(
  .HOST_BASE(HOST_BASE), .PROG_SPAN(PROG_SPAN), .PERIPH_BASE(PERIPH_BASE)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .cpuResetN    (cpuResetN),
  .cpuReq       (cpuReq),
  .cpuAddr      (cpuAddr),
  .hostRd       (hostRd),
  .hostWr       (hostWr),
  .hostAddr     (hostAddr),
  .cpuPeriphSel (cpuPeriphSel),
  .cpuRdata     (cpuRdata),
  .hostRdata    (hostRdata),
  .cpuProgStb   (strobes.cpuProg),
  .cpuBufStb    (strobes.cpuBuf),
  .hostProgStb  (strobes.hostProg)
);

// File: tb/shared_mem_decoder_tb_top.sv
`timescale 1ns/1ps
module shared_mem_decoder_tb_top;

  localparam logic [31:0] HB   = 32'h8000_0000;
  localparam int          PB   = 256;
  localparam int          BB   = 256;
  localparam int          NW   = 64;
  localparam logic [31:0] BUFC = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0, cpuResetN = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic [3:0]  cpuBe = '0;
  logic [31:0] cpuRdata, hostRdata;
  logic        cpuPeriphSel;
  logic [31:0] hostAddr = '0, hostWdata = '0;
  logic        hostRd = 1'b0, hostWr = 1'b0;
  logic [3:0]  hostBe = '0;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] progM [NW];
  logic [31:0] bufM  [NW];

  always #2.5 clk = ~clk;

  shared_mem_decoder #(.HOST_BASE(HB), .PROG_BYTES(PB), .BUF_BYTES(BB)) dut_i (
    .clk(clk), .rstN(rstN), .cpuResetN(cpuResetN),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuBe(cpuBe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuPeriphSel(cpuPeriphSel),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr), .hostBe(hostBe),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pf(input int i);
    return 32'hC0DE_0000 ^ (32'(i) * 32'h0101_0101);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = d[k*8 +: 8];
    return r;
  endfunction

  // One access cycle on either or both ports; returns read data and periph select
  task automatic cyc(input bit cR, input bit cW, input logic [31:0] cA, input logic [3:0] cB,
                     input logic [31:0] cD, input bit hR, input bit hW, input logic [31:0] hA,
                     input logic [3:0] hB, input logic [31:0] hD,
                     output logic [31:0] cQ, output logic [31:0] hQ, output logic ps);
    @(negedge clk);
    cpuReq = cR; cpuWe = cW; cpuAddr = cA; cpuBe = cB; cpuWdata = cD;
    hostRd = hR; hostWr = hW; hostAddr = hA; hostBe = hB; hostWdata = hD;
    #1 ps = cpuPeriphSel;
    @(negedge clk);
    cQ = cpuRdata; hQ = hostRdata;
    cpuReq = 0; cpuWe = 0; hostRd = 0; hostWr = 0;
  endtask

  task automatic cpuOp(input bit w, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] d, output logic [31:0] q, output logic ps);
    logic [31:0] hq;
    cyc(1, w, a, be, d, 0, 0, 32'h0, 4'h0, 32'h0, q, hq, ps);
  endtask

  task automatic hostOp(input bit w, input logic [31:0] a, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] q);
    logic [31:0] cq; logic ps;
    cyc(0, 0, 32'h0, 4'h0, 32'h0, !w, w, a, be, d, cq, q, ps);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, exp;
    logic ps;

    // R12: reset state
    repeat (3) @(negedge clk);
    check(cpuRdata == 0 && hostRdata == 0, "R12 reset rdata", cpuRdata | hostRdata, 0);
    rstN = 1;
    @(negedge clk);
    check(cpuRdata == 0 && hostRdata == 0, "R12 after reset", cpuRdata | hostRdata, 0);

    // R3/R4: host loads program RAM while CPU held in reset
    for (int i = 0; i < NW; i++) begin
      progM[i] = pf(i);
      hostOp(1, HB + 32'(4*i), 4'hF, pf(i), q);
    end
    for (int i = 0; i < NW; i++) begin
      hostOp(0, HB + 32'(4*i), 4'h0, 0, q);
      check(q == progM[i], "R3 R4 host prog readback in reset", q, progM[i]);
    end

    // R10: release CPU, fetch boot and interrupt words
    cpuResetN = 1;
    cpuOp(0, 32'h0, 0, 0, q, ps);
    check(q == progM[0], "R10 boot vector", q, progM[0]);
    cpuOp(0, 32'h20, 0, 0, q, ps);
    check(q == progM[8], "R10 interrupt entry", q, progM[8]);

    // R1: CPU reads program RAM and its alias copies
    for (int i = 0; i < NW; i++) begin
      cpuOp(0, 32'(4*i), 0, 0, q, ps);
      check(q == progM[i], "R1 cpu prog read", q, progM[i]);
      cpuOp(0, 32'(4*i + PB * (1 + i % 8)), 0, 0, q, ps);
      check(q == progM[i], "R1 cpu prog alias", q, progM[i]);
    end
    cpuOp(0, 32'h7FFC, 0, 0, q, ps);
    check(q == progM[NW-1], "R1 top of window", q, progM[NW-1]);

    // R4: lockout while running
    hostOp(1, HB + 32'hC, 4'hF, 32'hDEAD_BEEF, q);
    hostOp(0, HB + 32'hC, 0, 0, q);
    check(q == 0, "R4 blocked host read", q, 0);
    cpuOp(0, 32'hC, 0, 0, q, ps);
    check(q == progM[3], "R4 blocked host write dropped", q, progM[3]);

    // R2/R5: host fills buffer, CPU reads it
    for (int i = 0; i < NW; i++) begin
      bufM[i] = ~pf(i);
      hostOp(1, HB + 32'h8000 + 32'(4*i), 4'hF, bufM[i], q);
    end
    for (int i = 0; i < NW; i++) begin
      cpuOp(0, BUFC + 32'(4*i), 0, 0, q, ps);
      check(q == bufM[i], "R2 R5 cpu reads host data", q, bufM[i]);
    end
    // R5: CPU fills buffer, host reads it
    for (int i = 0; i < NW; i++) begin
      bufM[i] = pf(i) + 32'h1111;
      cpuOp(1, BUFC + 32'(4*i), 4'hF, bufM[i], q, ps);
    end
    for (int i = 0; i < NW; i++) begin
      hostOp(0, HB + 32'h8000 + 32'(4*i), 0, 0, q);
      check(q == bufM[i], "R5 R3 host reads cpu data", q, bufM[i]);
    end

    // R6: all byte-enable patterns
    for (int be = 0; be < 16; be++) begin
      cpuOp(1, BUFC + 32'h14, 4'hF, 32'h0, q, ps);
      cpuOp(1, BUFC + 32'h14, 4'(be), 32'h1122_3344, q, ps);
      exp = merge(32'h0, 32'h1122_3344, 4'(be));
      hostOp(0, HB + 32'h8014, 0, 0, q);
      check(q == exp, "R6 byte enables", q, exp);
    end
    bufM[5] = exp;

    // R7: same-cycle writes, every enable pairing
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [31:0] cq, hq, cd, hd;
        cd = 32'hAAAA_AAAA ^ 32'(a);
        hd = 32'h5555_5555 ^ 32'(b << 8);
        cpuOp(1, BUFC + 32'h1C, 4'hF, 32'h0F0F_0F0F, q, ps);
        cyc(1, 1, BUFC + 32'h1C, 4'(a), cd, 0, 1, HB + 32'h801C, 4'(b), hd, cq, hq, ps);
        exp = merge(merge(32'h0F0F_0F0F, hd, 4'(b)), cd, 4'(a));
        hostOp(0, HB + 32'h801C, 0, 0, q);
        check(q == exp, "R7 collision priority", q, exp);
      end
    end
    bufM[7] = exp;

    // R11: read-first on write
    cpuOp(1, BUFC + 32'h24, 4'hF, 32'h9999_0000, q, ps);
    check(q == bufM[9], "R11 old data on write", q, bufM[9]);
    hostOp(1, HB + 32'h8024, 4'hF, 32'h7777_1234, q);
    check(q == 32'h9999_0000, "R11 host old data on write", q, 32'h9999_0000);
    bufM[9] = 32'h7777_1234;
    cpuOp(0, BUFC + 32'h24, 0, 0, q, ps);
    check(q == bufM[9], "R11 new data after write", q, bufM[9]);

    // R8: peripheral space
    for (int k = 0; k < 64; k++) begin
      cpuOp(1, 32'hFFFF_FF00 + 32'(4*k), 4'hF, 32'hFFFF_FFFF, q, ps);
      check(ps == 1, "R8 periph select", 32'(ps), 1);
      check(q == 0, "R8 periph rdata zero", q, 0);
    end
    cpuOp(0, 32'hFFFF_FEFC, 0, 0, q, ps);
    check(ps == 0, "R8 below periph base", 32'(ps), 0);
    cpuOp(0, 32'h0, 0, 0, q, ps);
    check(q == progM[0], "R8 prog untouched", q, progM[0]);
    cpuOp(0, BUFC, 0, 0, q, ps);
    check(q == bufM[0], "R8 buffer untouched", q, bufM[0]);

    // R9: unmapped addresses
    cpuOp(1, BUFC + 32'(BB), 4'hF, 32'h1234_5678, q, ps);
    cpuOp(0, BUFC + 32'(BB), 0, 0, q, ps);
    check(q == 0, "R9 cpu unmapped read", q, 0);
    hostOp(1, HB + 32'h8000 + 32'(BB), 4'hF, 32'h2222_2222, q);
    hostOp(1, HB - 32'h4, 4'hF, 32'h3333_3333, q);
    hostOp(1, 32'h0, 4'hF, 32'h4444_4444, q);
    hostOp(0, HB - 32'h4, 0, 0, q);
    check(q == 0, "R9 host below base", q, 0);
    hostOp(0, HB + 32'h8000 + 32'(BB), 0, 0, q);
    check(q == 0, "R9 host past buffer", q, 0);
    cpuOp(0, BUFC, 0, 0, q, ps);
    check(q == bufM[0], "R9 buffer word 0 unchanged", q, bufM[0]);
    cpuOp(0, BUFC + 32'(BB - 4), 0, 0, q, ps);
    check(q == bufM[NW-1], "R9 buffer top unchanged", q, bufM[NW-1]);
    cpuOp(0, 32'(PB - 4), 0, 0, q, ps);
    check(q == progM[NW-1], "R9 prog top unchanged", q, progM[NW-1]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule